// File: doc/BRIEF.md
# SPI serial clock rate generator

This block turns the module clock into the serial-clock timing for an SPI transfer engine. It holds one clock-rate control word at offset 0x24 and, from it, produces a single-cycle toggle-enable pulse every half period of the serial clock, together with the serial clock level itself. The engine flips its shift and sample logic on each pulse. Two divider modes share the control word: an exponent-coded divider (period 2^n module clocks) and a linear divider (period 2*(m+1) module clocks). A mode bit chooses between them.

The generator runs only while the engine reports a burst in progress. Its counter restarts at the start of each burst, so the first serial clock edge comes one half period after the start. Software writes the control word before a transfer. A write made in the middle of a burst is held back and applied at the next byte boundary the engine reports, so the serial clock frequency never changes inside a byte. While idle, the serial clock rests at the level given by the clock polarity input. Choosing the best divider value is left to software.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset the control word reads 0, `sclk_tick` is 0 and `sclk` is 0.
- R2: A write with `cfg_addr` equal to 0x24 stores `cfg_wdata[12:0]`. Bit 12 is the mode select, bits 11:8 are the exponent field n and bits 7:0 are the linear field m. A read at 0x24 returns the stored bits with bits 31:13 as 0. Writes to any other address leave the word unchanged, and reads at any other address return 0.
- R3: With bit 12 = 0, ticks are spaced 2^(n-1) module clocks apart, which gives a serial clock period of 2^n. A value of n = 0 behaves as n = 1.
- R4: With bit 12 = 1, ticks are spaced m+1 module clocks apart, which gives a serial clock period of 2*(m+1).
- R5: `sclk_tick` is 0 whenever `burst_active` is 0. From the clock edge after a cycle with `burst_active` at 0, `sclk` equals the `cpol` input sampled in that cycle.
- R6: A burst starts in the first cycle with `burst_active` at 1, counted as cycle 0. For a spacing of h, ticks occur exactly in cycles h-1, 2h-1, 3h-1 and so on, with no other ticks.
- R7: `sclk` inverts at the clock edge that ends each tick cycle and holds its value in all other burst cycles. Its duty cycle is therefore 50%.
- R8: A write made during a burst does not change the tick spacing until a cycle with `byte_boundary` at 1. At the edge ending that cycle, the new spacing is loaded and the counter restarts, so the next tick comes a full new spacing after that cycle.
- R9: A write made while idle governs the next burst from its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register readback for `cfg_addr` |
| cpol | input | 1 | Idle level of the serial clock |
| burst_active | input | 1 | Engine reports a burst in progress |
| byte_boundary | input | 1 | Engine marks the cycle that ends a byte |
| sclk_tick | output | 1 | Half-period toggle-enable pulse |
| sclk | output | 1 | Serial clock level |

## Verification
Bursts are run with several divider settings in each mode. These include the fastest setting (one clock per half period, from n = 0, n = 1 and m = 0), middle values (n = 3, m = 2), the largest exponent n = 15, and a large linear value m = 165. Between them, these settings separate an off-by-one in either formula, a missing n = 0 clamp, and a swapped mode bit. One burst uses `cpol` at 1 to show that the idle level and the tick-edge levels follow polarity rather than a fixed value. A dedicated burst writes a new rate in the middle of a byte and then marks a byte boundary. This shows that the spacing holds until the boundary and that the counter restarts there. Writes to a neighbouring address, and write data with high bits set, show that only the 13 defined bits at 0x24 are stored.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
    parameter int EXP_W  = 4;
    parameter int LIN_W  = 8;
    localparam int REG_W = 1 + EXP_W + LIN_W;
    localparam int EXP_HALF_W = (1 << EXP_W) - 1;
    localparam int LIN_HALF_W = LIN_W + 1;
    localparam int HALF_W = (EXP_HALF_W > LIN_HALF_W) ? EXP_HALF_W : LIN_HALF_W;

    typedef struct packed {
        logic             lin_mode;
        logic [EXP_W-1:0] exp_div;
        logic [LIN_W-1:0] lin_div;
    } div_cfg_t;

    // Module clocks per half period of the serial clock
    function automatic logic [HALF_W-1:0] half_of(input div_cfg_t c);
        logic [HALF_W-1:0] one;
        int unsigned       n;
        one = HALF_W'(1);
        if (c.lin_mode) begin
            return HALF_W'(c.lin_div) + one;
        end
        n = (c.exp_div == '0) ? 1 : int'(c.exp_div);
        return one << (n - 1);
    endfunction
endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg
    import sclk_div_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              burst_active,
    input  logic              byte_boundary,
    output logic [HALF_W-1:0] act_half
);
    typedef struct packed {
        div_cfg_t          shadow;
        logic [HALF_W-1:0] half;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       hit;
    logic       unused_hi;

    assign hit       = (addr == REG_OFFSET);
    assign unused_hi = ^wdata[DATA_W-1:REG_W];

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.shadow = div_cfg_t'(wdata[REG_W-1:0]);
        end
        // Rate changes only while idle or at a byte boundary
        if (!burst_active || byte_boundary) begin
            st_d.half = half_of(st_d.shadow);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shadow <= '0;
            st_q.half   <= HALF_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = hit ? {{(DATA_W-REG_W){1'b0}}, st_q.shadow} : '0;
    assign act_half = st_q.half;
endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter
    import sclk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_active,
    input  logic              restart,
    input  logic              cpol,
    input  logic [HALF_W-1:0] half,
    output logic              tick,
    output logic              sclk
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              lvl;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign tick = burst_active && (st_q.cnt >= (half - 1'b1));

    always_comb begin
        st_d = st_q;
        if (!burst_active) begin
            st_d.cnt = '0;
            st_d.lvl = cpol;
        end else begin
            st_d.lvl = st_q.lvl ^ tick;
            st_d.cnt = (tick || restart) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.lvl;
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
    import sclk_div_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              cpol,
    input  logic              burst_active,
    input  logic              byte_boundary,
    output logic              sclk_tick,
    output logic              sclk
);
    logic [HALF_W-1:0] act_half;

    sclk_cfg_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_OFFSET(REG_OFFSET)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_wr_en),
        .addr         (cfg_addr),
        .wdata        (cfg_wdata),
        .rdata        (cfg_rdata),
        .burst_active (burst_active),
        .byte_boundary(byte_boundary),
        .act_half     (act_half)
    );

    sclk_half_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_active(burst_active),
        .restart     (byte_boundary),
        .cpol        (cpol),
        .half        (act_half),
        .tick        (sclk_tick),
        .sclk        (sclk)
    );
endmodule

// File: rtl/sclk_rate_chk.sv
module sclk_rate_chk
    import sclk_div_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              burst_active,
    input logic              byte_boundary,
    input logic              cpol,
    input logic              sclk,
    input logic              sclk_tick,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [HALF_W-1:0] act_half
);
    // R5
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> !sclk_tick);

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |=> (sclk == $past(cpol)));

    // R7
    tick_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && sclk_tick) |=> (sclk != $past(sclk)));

    // R7
    hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !sclk_tick) |=> $stable(sclk));

    // R8
    rate_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !byte_boundary) |=> $stable(act_half));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:REG_W] == '0);
endmodule

bind sclk_rate_gen sclk_rate_chk #(.DATA_W(DATA_W)) u_sclk_rate_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_active (burst_active),
    .byte_boundary(byte_boundary),
    .cpol         (cpol),
    .sclk         (sclk),
    .sclk_tick    (sclk_tick),
    .cfg_rdata    (cfg_rdata),
    .act_half     (act_half)
);

// File: tb/tb_sclk_rate_gen.sv
module tb_sclk_rate_gen;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_wr_en = 0;
    logic [7:0]  cfg_addr = 8'h24;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cpol = 0;
    logic        burst_active = 0;
    logic        byte_boundary = 0;
    logic        sclk_tick;
    logic        sclk;

    typedef struct {
        int   cyc;
        logic lvl;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;

    sclk_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpol(cpol),
        .burst_active(burst_active), .byte_boundary(byte_boundary),
        .sclk_tick(sclk_tick), .sclk(sclk)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pops expected tick cycles as the design produces them
    always @(negedge clk) begin
        cyc++;
        if (rst_n && sclk_tick) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected tick", cyc, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cyc == e.cyc, "R6 tick cycle", cyc, e.cyc);
                chk(sclk == e.lvl, "R7 level at tick", sclk, e.lvl);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_wr_en = 0; cfg_addr = 8'h24;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [31:0] expv, input string tag);
        cfg_addr = a;
        @(negedge clk);
        chk(cfg_rdata == expv, tag, cfg_rdata, expv);
        step();
        cfg_addr = 8'h24;
    endtask

    task automatic burst_tail(input string tag);
        step();
        @(negedge clk);
        chk(exp_q.size() == 0, {tag, " R6 missing ticks"}, exp_q.size(), 0);
        chk(sclk == cpol, "R5 idle level", sclk, cpol);
        chk(sclk_tick == 0, "R5 idle tick", sclk_tick, 0);
        exp_q.delete();
        step();
    endtask

    // Driver: queue expected ticks for spacing h, then run the burst
    task automatic run_burst(input int h, input int nt, input string tag);
        int start;
        start = cyc + 1;
        for (int k = 0; k < nt; k++) begin
            exp_q.push_back('{start + h - 1 + k * h, cpol ^ logic'(k % 2)});
        end
        burst_active = 1;
        repeat (nt * h) step();
        burst_active = 0;
        burst_tail(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        chk(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int start;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);
        chk(sclk == 0, "R1 sclk", sclk, 0);
        chk(sclk_tick == 0, "R1 tick", sclk_tick, 0);
        step();
        // R3 n=0 behaves as n=1: spacing 1
        run_burst(1, 4, "R3 n0");
        // R2 only low 13 bits stored
        write_reg(8'h24, 32'hFFFF_F3A5);
        read_check(8'h24, 32'h0000_13A5, "R2 readback");
        write_reg(8'h20, 32'h0000_0000);
        read_check(8'h24, 32'h0000_13A5, "R2 other addr write ignored");
        read_check(8'h20, 32'h0, "R2 other addr reads 0");
        // R4 m=165 -> spacing 166 ; R9 idle write governs next burst
        run_burst(166, 2, "R4 m165 R9");
        write_reg(8'h24, 32'h0000_0100);
        run_burst(1, 3, "R3 n1");
        write_reg(8'h24, 32'h0000_0300);
        run_burst(4, 3, "R3 n3");
        write_reg(8'h24, 32'h0000_0F00);
        run_burst(16384, 1, "R3 n15");
        write_reg(8'h24, 32'h0000_1000);
        run_burst(1, 3, "R4 m0");
        cpol = 1;
        write_reg(8'h24, 32'h0000_1002);
        step();
        run_burst(3, 4, "R4 m2 cpol1");
        cpol = 0;
        step();
        // R8 mid-burst write held until byte boundary
        write_reg(8'h24, 32'h0000_1001);
        start = cyc + 1;
        exp_q.push_back('{start + 1, 1'b0});
        exp_q.push_back('{start + 3, 1'b1});
        exp_q.push_back('{start + 5, 1'b0});
        exp_q.push_back('{start + 9, 1'b1});
        exp_q.push_back('{start + 13, 1'b0});
        for (int i = 0; i < 14; i++) begin
            burst_active  = 1;
            cfg_wr_en     = (i == 2);
            cfg_addr      = 8'h24;
            cfg_wdata     = 32'h0000_0300;
            byte_boundary = (i == 5);
            step();
        end
        cfg_wr_en = 0; byte_boundary = 0; burst_active = 0;
        burst_tail("R8 boundary");
        read_check(8'h24, 32'h0000_0300, "R8 readback");
        // R9 new rate active from first cycle of next burst
        run_burst(4, 2, "R9 next burst");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule